// File: doc/BRIEF.md
# Oscillator Entropy Word Collector

The collector turns a bank of free-running oscillator lines into 32-bit entropy words. Every oscillator line is asynchronous to the system clock. Each line first passes through a two-flop synchroniser. A prescaler then opens a sample point once every `SAMPLE_WRAP` clocks. At that point the synchronised lines are XOR-reduced to one raw bit, and the bit is shifted into an assembly register. After 32 raw bits, the assembled word moves to an output register, and a valid flag stays raised until the consumer acknowledges it. Collection keeps running while a word waits. A later word overwrites an unacknowledged one.

After reset, a warm-up counter loaded with `WARMUP_CYCLES` counts samples down. Words that complete before it reaches zero are thrown away, which gives the oscillators time to drift apart. A free-running debug timer copies the low byte of the output word into a debug register every `DEBUG_DELAY` clocks and pulses a strobe when it does. The block also holds the oscillator operand words and the oscillator enable in its own registers and drives them out as ports. Keeping these values in registers stops synthesis from folding the oscillator adders away. A small write port updates these registers.

Top module: `ewc_collector`

## Requirements
- R1: While `rst_n` is low, `word_out`, `word_valid`, `dbg_byte` and `dbg_upd` are zero, `op_a`/`op_b` hold `DEF_OP_A`/`DEF_OP_B` and `osc_enable` is 1.
- R2: While enabled, one sample is taken every `SAMPLE_WRAP` clocks. The first sample falls on the `SAMPLE_WRAP`-th rising edge after reset release. Its raw bit is the XOR of all `osc_in` lines as they stood two clocks earlier, so toggling an even number of lines together never changes it.
- R3: Raw bits enter at bit 0 and move toward bit 31. The word therefore carries its oldest sample in bit 31. One clock after the 32nd sample of a word, `word_out` takes the word and `word_valid` rises. At no other time does `word_out` change.
- R4: Each sample while the warm-up counter is non-zero decrements it. A word whose 32nd sample is sample number n (counted from 1 since reset) is delivered only if n >= `WARMUP_CYCLES`. Other words leave `word_out` and `word_valid` untouched.
- R5: `word_ack` high while `word_valid` is high clears `word_valid` on the next edge, unless a new word completes on that same edge. Without an acknowledge, `word_valid` stays high.
- R6: While `osc_enable` is low, the sample counter, the bit counter and `word_valid` are forced to zero, no bits are shifted in and `word_out` keeps its value.
- R7: `dbg_upd` is a one-clock pulse every `DEBUG_DELAY` clocks. The first pulse follows the `DEBUG_DELAY`-th edge after reset release. During the pulse, `dbg_byte` equals `word_out[7:0]` as it stood one clock earlier.
- R8: With `cfg_wr` high, `cfg_sel` 0 writes `cfg_wdata[0]` to `osc_enable`, 1 writes `op_a`, and 2 writes `op_b`. Each new value appears on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | NUM_OSC | Asynchronous oscillator lines |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 operand A, 2 operand B |
| cfg_wdata | input | OP_W | Configuration write data |
| op_a | output | OP_W | Operand A to the oscillator adders |
| op_b | output | OP_W | Operand B to the oscillator adders |
| osc_enable | output | 1 | Oscillator and collection enable |
| word_out | output | WORD_W | Last delivered entropy word |
| word_valid | output | 1 | Word waiting for the consumer |
| word_ack | input | 1 | Consumer acknowledge |
| dbg_byte | output | DBG_W | Debug snapshot of the word's low byte |
| dbg_upd | output | 1 | One-clock pulse on each debug refresh |

## Verification
The bench changes oscillator patterns only mid-interval and adds simultaneous toggles on line pairs at odd times. A design that reduced the lines with anything other than XOR, or sampled the lines off its prescaler, delivers words that differ from the scoreboard. The warm-up bound is placed between the first and second word. Delivering the first word, or suppressing the second, shows up as an extra or missing word. Acknowledges are checked one clock later, and the last word is left unacknowledged to confirm that valid holds. Disabling while a word waits must drop valid and freeze the word. The debug strobe is checked for exact spacing and for the byte it carries.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  localparam int SAMP_CNT_W = 8;
  localparam int BIT_CNT_W  = 8;
  localparam int DBG_CNT_W  = 32;
  localparam int WARM_CNT_W = 32;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_OP_A   = 2'd1,
    CFG_OP_B   = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/ewc_sync.sv
module ewc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/ewc_sampler.sv
module ewc_sampler
  import ewc_pkg::*;
#(
  parameter int              NUM_OSC       = 32,
  parameter int              SAMPLE_WRAP   = 200,
  parameter logic [31:0]     WARMUP_CYCLES = 32'd1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [NUM_OSC-1:0]    osc_sync,
  output logic                  samp_tick,
  output logic                  samp_bit,
  output logic                  warm_done,
  output logic [SAMP_CNT_W-1:0] samp_cnt,
  output logic [WARM_CNT_W-1:0] warm_cnt
);
  localparam logic [SAMP_CNT_W-1:0] WRAP_LAST = SAMP_CNT_W'(SAMPLE_WRAP - 1);

  logic [SAMP_CNT_W-1:0] cnt_q, cnt_d;
  logic [WARM_CNT_W-1:0] warm_q, warm_d;
  logic                  tick_q, tick_d;
  logic                  bit_q, bit_d;
  logic                  wrap;

  always_comb begin
    wrap   = (cnt_q == WRAP_LAST);
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    bit_d  = bit_q;
    warm_d = warm_q;
    if (!enable) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d  = '0;
      tick_d = 1'b1;
      bit_d  = ^osc_sync;
      if (warm_q != '0) warm_d = warm_q - WARM_CNT_W'(1);
    end else begin
      cnt_d = cnt_q + SAMP_CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      bit_q  <= 1'b0;
      warm_q <= WARMUP_CYCLES;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
      bit_q  <= bit_d;
      warm_q <= warm_d;
    end
  end

  assign samp_tick = tick_q;
  assign samp_bit  = bit_q;
  assign warm_done = (warm_q == '0);
  assign samp_cnt  = cnt_q;
  assign warm_cnt  = warm_q;
endmodule

// File: rtl/ewc_assembler.sv
module ewc_assembler
  import ewc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 samp_tick,
  input  logic                 samp_bit,
  input  logic                 warm_done,
  input  logic                 ack,
  output logic [WORD_W-1:0]    word_out,
  output logic                 word_valid,
  output logic                 word_deliver,
  output logic [BIT_CNT_W-1:0] bit_cnt
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0]    shift_q, shift_d;
  logic [WORD_W-1:0]    word_q, word_d;
  logic                 valid_q, valid_d;
  logic [BIT_CNT_W-1:0] cnt_q, cnt_d;
  logic                 deliver;

  always_comb begin
    shift_d = shift_q;
    word_d  = word_q;
    valid_d = valid_q;
    cnt_d   = cnt_q;
    deliver = 1'b0;
    if (!enable) begin
      cnt_d   = '0;
      valid_d = 1'b0;
    end else begin
      if (valid_q && ack) valid_d = 1'b0;
      if (samp_tick) begin
        shift_d = {shift_q[WORD_W-2:0], samp_bit};
        if (cnt_q == LAST_BIT) begin
          cnt_d = '0;
          if (warm_done) begin
            deliver = 1'b1;
            word_d  = shift_d;
            valid_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + BIT_CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      shift_q <= shift_d;
      word_q  <= word_d;
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
    end
  end

  assign word_out     = word_q;
  assign word_valid   = valid_q;
  assign word_deliver = deliver;
  assign bit_cnt      = cnt_q;
endmodule

// File: rtl/ewc_debug.sv
module ewc_debug
  import ewc_pkg::*;
#(
  parameter int          DBG_W       = 8,
  parameter logic [31:0] DEBUG_DELAY = 32'd100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DBG_W-1:0] src,
  output logic [DBG_W-1:0] dbg_byte,
  output logic             dbg_upd
);
  localparam logic [DBG_CNT_W-1:0] DLY_LAST = DBG_CNT_W'(DEBUG_DELAY - 32'd1);

  logic [DBG_CNT_W-1:0] cnt_q, cnt_d;
  logic [DBG_W-1:0]     byte_q, byte_d;
  logic                 upd_q, upd_d;

  always_comb begin
    byte_d = byte_q;
    upd_d  = 1'b0;
    if (cnt_q == DLY_LAST) begin
      cnt_d  = '0;
      byte_d = src;
      upd_d  = 1'b1;
    end else begin
      cnt_d = cnt_q + DBG_CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      byte_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
      upd_q  <= upd_d;
    end
  end

  assign dbg_byte = byte_q;
  assign dbg_upd  = upd_q;
endmodule

// File: rtl/ewc_cfg.sv
module ewc_cfg
  import ewc_pkg::*;
#(
  parameter int            OP_W     = 32,
  parameter logic [OP_W-1:0] DEF_OP_A = '0,
  parameter logic [OP_W-1:0] DEF_OP_B = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [1:0]      sel,
  input  logic [OP_W-1:0] wdata,
  output logic [OP_W-1:0] op_a,
  output logic [OP_W-1:0] op_b,
  output logic            enable
);
  logic [OP_W-1:0] a_q, a_d, b_q, b_d;
  logic            en_q, en_d;

  always_comb begin
    a_d  = a_q;
    b_d  = b_q;
    en_d = en_q;
    if (wr) begin
      case (cfg_sel_e'(sel))
        CFG_ENABLE: en_d = wdata[0];
        CFG_OP_A:   a_d  = wdata;
        CFG_OP_B:   b_d  = wdata;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= DEF_OP_A;
      b_q  <= DEF_OP_B;
      en_q <= 1'b1;
    end else begin
      a_q  <= a_d;
      b_q  <= b_d;
      en_q <= en_d;
    end
  end

  assign op_a   = a_q;
  assign op_b   = b_q;
  assign enable = en_q;
endmodule

// File: rtl/ewc_collector.sv
module ewc_collector
  import ewc_pkg::*;
#(
  parameter int              NUM_OSC       = 32,
  parameter int              WORD_W        = 32,
  parameter int              DBG_W         = 8,
  parameter int              OP_W          = 32,
  parameter int              SAMPLE_WRAP   = 200,
  parameter logic [31:0]     WARMUP_CYCLES = 32'd1000,
  parameter logic [31:0]     DEBUG_DELAY   = 32'd100000,
  parameter logic [OP_W-1:0] DEF_OP_A      = 32'haaaa_aaaa,
  parameter logic [OP_W-1:0] DEF_OP_B      = 32'h5555_5555
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OSC-1:0] osc_in,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_sel,
  input  logic [OP_W-1:0]    cfg_wdata,
  output logic [OP_W-1:0]    op_a,
  output logic [OP_W-1:0]    op_b,
  output logic               osc_enable,
  output logic [WORD_W-1:0]  word_out,
  output logic               word_valid,
  input  logic               word_ack,
  output logic [DBG_W-1:0]   dbg_byte,
  output logic               dbg_upd
);
  logic [NUM_OSC-1:0]    osc_sync;
  logic                  samp_tick;
  logic                  samp_bit;
  logic                  warm_done;
  logic [SAMP_CNT_W-1:0] samp_cnt;
  logic [WARM_CNT_W-1:0] warm_cnt;
  logic                  word_deliver;
  logic [BIT_CNT_W-1:0]  bit_cnt;

  ewc_cfg #(.OP_W(OP_W), .DEF_OP_A(DEF_OP_A), .DEF_OP_B(DEF_OP_B)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .op_a(op_a), .op_b(op_b), .enable(osc_enable)
  );

  ewc_sync #(.W(NUM_OSC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(osc_in), .q(osc_sync)
  );

  ewc_sampler #(
    .NUM_OSC(NUM_OSC), .SAMPLE_WRAP(SAMPLE_WRAP), .WARMUP_CYCLES(WARMUP_CYCLES)
  ) u_sampler (
    .clk(clk), .rst_n(rst_n), .enable(osc_enable), .osc_sync(osc_sync),
    .samp_tick(samp_tick), .samp_bit(samp_bit), .warm_done(warm_done),
    .samp_cnt(samp_cnt), .warm_cnt(warm_cnt)
  );

  ewc_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .enable(osc_enable), .samp_tick(samp_tick),
    .samp_bit(samp_bit), .warm_done(warm_done), .ack(word_ack),
    .word_out(word_out), .word_valid(word_valid),
    .word_deliver(word_deliver), .bit_cnt(bit_cnt)
  );

  ewc_debug #(.DBG_W(DBG_W), .DEBUG_DELAY(DEBUG_DELAY)) u_dbg (
    .clk(clk), .rst_n(rst_n), .src(word_out[DBG_W-1:0]),
    .dbg_byte(dbg_byte), .dbg_upd(dbg_upd)
  );
endmodule

// File: rtl/ewc_collector_chk.sv
module ewc_collector_chk
  import ewc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DBG_W  = 8,
  parameter int OP_W   = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_wr,
  input logic [1:0]            cfg_sel,
  input logic [OP_W-1:0]       cfg_wdata,
  input logic [OP_W-1:0]       op_a,
  input logic                  osc_enable,
  input logic [WORD_W-1:0]     word_out,
  input logic                  word_valid,
  input logic                  word_ack,
  input logic                  word_deliver,
  input logic [BIT_CNT_W-1:0]  bit_cnt,
  input logic [SAMP_CNT_W-1:0] samp_cnt,
  input logic [WARM_CNT_W-1:0] warm_cnt,
  input logic [DBG_W-1:0]      dbg_byte,
  input logic                  dbg_upd
);
  assert_word_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_deliver |=> $stable(word_out));

  assert_bitcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < BIT_CNT_W'(WORD_W));

  assert_no_valid_warm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt != '0) |-> !word_valid);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ack && !word_deliver) |=> !word_valid);

  assert_disable_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_enable |=> (!word_valid && bit_cnt == '0 && samp_cnt == '0));

  assert_dbg_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_upd |-> dbg_byte == $past(word_out[DBG_W-1:0]));

  assert_opa_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == 2'd1) |=> op_a == $past(cfg_wdata));
endmodule

bind ewc_collector ewc_collector_chk #(.WORD_W(WORD_W), .DBG_W(DBG_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .op_a(op_a), .osc_enable(osc_enable), .word_out(word_out), .word_valid(word_valid),
  .word_ack(word_ack), .word_deliver(word_deliver), .bit_cnt(bit_cnt),
  .samp_cnt(samp_cnt), .warm_cnt(warm_cnt), .dbg_byte(dbg_byte), .dbg_upd(dbg_upd)
);

// File: tb/ewc_collector_test.sv
`timescale 1ns/1ps
module ewc_collector_test;
  localparam int          WRAP   = 8;
  localparam int          WARM   = 40;
  localparam int          DLY    = 100;
  localparam int          SLOTS  = 192;
  localparam logic [31:0] DEF_A  = 32'haaaa_aaaa;
  localparam logic [31:0] DEF_B  = 32'h5555_5555;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] osc_in;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] op_a, op_b;
  logic        osc_enable;
  logic [31:0] word_out;
  logic        word_valid;
  logic        word_ack;
  logic [7:0]  dbg_byte;
  logic        dbg_upd;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int words_seen = 0;
  logic [31:0] exp_q[$];

  ewc_collector #(
    .SAMPLE_WRAP(WRAP), .WARMUP_CYCLES(WARM), .DEBUG_DELAY(DLY),
    .DEF_OP_A(DEF_A), .DEF_OP_B(DEF_B)
  ) uut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .op_a(op_a), .op_b(op_b), .osc_enable(osc_enable),
    .word_out(word_out), .word_valid(word_valid), .word_ack(word_ack),
    .dbg_byte(dbg_byte), .dbg_upd(dbg_upd)
  );

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int j);
    case (j % 5)
      0:       return 32'h0;
      1:       return 32'hffff_ffff;
      2:       return 32'h1 << (j % 32);
      default: return (32'h9e37_79b9 * (j + 1)) ^ (32'(j) << 7);
    endcase
  endfunction

  // Driver: one pattern per sample interval, set mid-interval; expected words go to the queue
  task automatic drive();
    logic [31:0] w = '0;
    for (int j = 0; j < SLOTS; j++) begin
      wait_cyc(j * WRAP + WRAP / 2);
      osc_in = pat(j);
      w = {w[30:0], ^pat(j)};
      if (((j + 1) % 32 == 0) && (j + 1 >= WARM)) exp_q.push_back(w);
      wait_cyc(j * WRAP + WRAP / 2 + 2);
      #1.5;
      osc_in[j % 32]       = ~osc_in[j % 32];
      osc_in[(j + 11) % 32] = ~osc_in[(j + 11) % 32];
    end
  endtask

  // Monitor: compares each delivered word with the scoreboard, acknowledges all but the last
  initial begin
    logic prev_valid = 1'b0;
    logic [31:0] e;
    word_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && word_valid && !prev_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected word", word_out, 32'h0);
        end else begin
          e = exp_q.pop_front();
          check(word_out == e, "R2 R3 word", word_out, e);
        end
        words_seen++;
        if (words_seen < 5) begin
          word_ack = 1'b1;
          @(negedge clk);
          word_ack = 1'b0;
          check(!word_valid, "R5 ack clears valid", 32'(word_valid), 32'h0);
        end
      end
      prev_valid = word_valid;
    end
  end

  // Debug strobe monitor
  initial begin
    logic [31:0] prev_word = '0;
    int last = 0;
    forever begin
      @(negedge clk);
      if (rst_n && dbg_upd) begin
        check(dbg_byte == prev_word[7:0], "R7 debug byte", 32'(dbg_byte), 32'(prev_word[7:0]));
        check(cyc - last == DLY, "R7 debug spacing", 32'(cyc - last), 32'(DLY));
        last = cyc;
      end
      prev_word = word_out;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'(cyc), 32'h0);
    summary();
  end

  initial begin
    logic [31:0] frozen;
    rst_n = 1'b0; osc_in = '0; cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check(word_out == '0, "R1 word reset", word_out, 32'h0);
    check(!word_valid, "R1 valid reset", 32'(word_valid), 32'h0);
    check(dbg_byte == '0 && !dbg_upd, "R1 debug reset", {23'h0, dbg_upd, dbg_byte}, 32'h0);
    check(op_a == DEF_A, "R1 op_a reset", op_a, DEF_A);
    check(op_b == DEF_B, "R1 op_b reset", op_b, DEF_B);
    check(osc_enable, "R1 enable reset", 32'(osc_enable), 32'h1);
    rst_n = 1'b1;
    fork drive(); join_none
    cfg_write(2'd1, 32'h1234_5678);
    check(op_a == 32'h1234_5678, "R8 op_a write", op_a, 32'h1234_5678);
    cfg_write(2'd2, 32'hcafe_f00d);
    check(op_b == 32'hcafe_f00d, "R8 op_b write", op_b, 32'hcafe_f00d);
    check(op_a == 32'h1234_5678, "R8 op_a kept", op_a, 32'h1234_5678);
    wait_cyc(32 * WRAP + 10);
    check(word_out == '0 && !word_valid, "R4 warm-up word dropped", word_out, 32'h0);
    while (words_seen < 5) @(negedge clk);
    repeat (5) @(negedge clk);
    check(word_valid, "R5 valid held without ack", 32'(word_valid), 32'h1);
    frozen = word_out;
    cfg_write(2'd0, 32'h0);
    check(!osc_enable, "R8 enable write", 32'(osc_enable), 32'h0);
    @(negedge clk);
    check(!word_valid, "R6 disable drops valid", 32'(word_valid), 32'h0);
    repeat (40 * WRAP) @(negedge clk);
    check(word_out == frozen, "R6 word frozen", word_out, frozen);
    check(!word_valid, "R6 valid stays low", 32'(word_valid), 32'h0);
    check(exp_q.size() == 0, "R3 all words delivered", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule